// File: doc/BRIEF.md
# DMA channel request scheduler

This block picks which DMA channel may move its next data element. For every channel it looks at the channel's configuration word, the count of elements still to move, and the peripheral request lines. It then issues a one-hot grant with a valid strobe to the transfer engine. Every cycle in which the strobe is high, the engine moves one element for the granted channel and lowers that channel's count by one. The new count is visible to the scheduler in the next cycle.

The scheduler looks at one channel per cycle, starting from channel 0 and moving upward. It stays on a channel for as long as that channel can still make progress. A pass that granted something is followed by a new pass. A pass that granted nothing puts the scheduler to sleep until a kick pulse arrives or the combined request vector changes. Either event restarts the scan at channel 0, even in the middle of a pass. Channels that select a flow type controlled by the peripheral are not served; instead they raise a per-channel error flag.

Top module: `dma_chan_sched`

## Requirements
- R1: No grant is issued while the global enable input is low.
- R2: A channel can be granted only when its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: Configuration bits 13:11 hold the flow type, bits 5:1 the source peripheral number and bits 10:6 the destination peripheral number. The request vector used is the bitwise OR of the single and burst request inputs.
- R4: Flow type 0 is granted without any request. Type 1 needs the destination peripheral's request bit, type 2 needs the source's, and type 3 needs both.
- R5: A channel whose remaining count is zero is never granted.
- R6: A scanned channel that is enabled, not halted, has a non-zero count and selects flow type 4 to 7 is not granted. While global enable is high, it sets its sticky error flag one cycle after it is visited. The flag clears one cycle after the channel's enable bit goes low.
- R7: Channels are examined in ascending order, and a granted channel is examined again in the next cycle. With static inputs, the grants of a pass therefore never go to a lower channel than the previous grant, and each eligible channel receives exactly as many grants as its count.
- R8: The grant vector is one-hot while valid is high and all zero otherwise. Valid is combinational in the current state and inputs.
- R9: A kick pulse, or any change in the OR of the request vectors, makes the scheduler examine channel 0 in the next cycle, even during a pass.
- R10: After a full pass with no grant the scheduler idles: it issues no grant, even for newly eligible channels, until an R9 event.
- R11: After reset the scheduler is idle, valid and grant are low, and all error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable |
| kick | input | 1 | Single-cycle pulse that starts a new scan |
| chan_cfg | input | NUM_CH*32 | Configuration words, channel c in bits c*32 upward |
| chan_cnt | input | NUM_CH*CNT_W | Remaining element counts, channel c in bits c*CNT_W upward |
| req_single | input | 32 | Single-transfer peripheral requests |
| req_burst | input | 32 | Burst peripheral requests |
| grant_vld | output | 1 | One element moves for the granted channel this cycle |
| grant | output | NUM_CH | One-hot grant |
| flow_err | output | NUM_CH | Sticky unsupported-flow-type flags |

## Verification
The bench builds the block with NUM_CH=4 and CNT_W=4. With these values it can sweep every channel against all eight flow types, each with every presence pattern of the source and destination requests, and alternate which request vector carries each bit. The small counts drain in a few cycles, so the wrap at the last channel and the idle state after an empty pass occur in nearly every case. This keeps pseudo-random multi-channel mixes, restarts in the middle of a pass and idle-without-kick checks short enough to run many times.

// File: rtl/dma_sched_pkg.sv
// Package: shared field positions and decoded configuration for the DMA
// channel scheduler. Assumes 32-bit configuration words and 32 request lines.
package dma_sched_pkg;

    localparam int CFG_W        = 32;
    localparam int REQ_W        = 32;
    localparam int PERIPH_W     = $clog2(REQ_W);
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_HALT_BIT = 18;
    localparam int SRC_LSB      = 1;
    localparam int DST_LSB      = 6;
    localparam int FLOW_LSB     = 11;

    typedef struct packed {
        logic                en;
        logic                halt;
        logic [2:0]          flow;
        logic [PERIPH_W-1:0] src;
        logic [PERIPH_W-1:0] dst;
    } chan_cfg_t;

    // Pull the scheduler-relevant fields out of one configuration word.
    function automatic chan_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        chan_cfg_t r;
        r.en   = w[CFG_EN_BIT];
        r.halt = w[CFG_HALT_BIT];
        r.flow = w[FLOW_LSB +: 3];
        r.src  = w[SRC_LSB +: PERIPH_W];
        r.dst  = w[DST_LSB +: PERIPH_W];
        return r;
    endfunction

endpackage

// File: rtl/dma_chan_elig.sv
// Module: per-channel eligibility. Purely combinational; decides whether a
// channel could move an element now, and whether it selects an unsupported
// flow type. Assumes the request vector is already the OR of both kinds.
module dma_chan_elig import dma_sched_pkg::*; #(
    parameter int CNT_W = 12
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [REQ_W-1:0] req_any_i,
    output logic             ready_o,
    output logic             bad_flow_o
);

    chan_cfg_t f;
    logic      active;
    logic      src_hit;
    logic      dst_hit;
    logic      req_ok;

    assign f = decode_cfg(cfg_i);

    // Channel is running with work left (R2, R5); look up its request lines (R3).
    always_comb begin
        active  = f.en & ~f.halt & (cnt_i != '0);
        src_hit = req_any_i[f.src];
        dst_hit = req_any_i[f.dst];
    end

    // Flow-type gating of the request lines (R4); types 4..7 never pass.
    always_comb begin
        case (f.flow)
            3'd0:    req_ok = 1'b1;
            3'd1:    req_ok = dst_hit;
            3'd2:    req_ok = src_hit;
            3'd3:    req_ok = src_hit & dst_hit;
            default: req_ok = 1'b0;
        endcase
    end

    // Final outputs: ready to grant, or flagged as unsupported (R6).
    always_comb begin
        ready_o    = active & req_ok;
        bad_flow_o = active & f.flow[2];
    end

endmodule

// File: rtl/dma_req_watch.sv
// Module: merges single and burst requests and flags any change of the
// merged vector against the previous cycle. Assumes request inputs are
// synchronous to clk.
module dma_req_watch import dma_sched_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] req_single_i,
    input  logic [REQ_W-1:0] req_burst_i,
    output logic [REQ_W-1:0] req_any_o,
    output logic             req_changed_o
);

    logic [REQ_W-1:0] prev_q;

    // Merge both request kinds (R3).
    always_comb req_any_o = req_single_i | req_burst_i;

    // Remember last cycle's merged vector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= req_any_o;
    end

    // Any bit difference is a change event (R9).
    always_comb req_changed_o = (req_any_o != prev_q);

endmodule

// File: rtl/dma_scan_ctl.sv
// Module: scan pointer and pass control. Visits one channel per cycle,
// holds on a channel while it is ready, wraps after the last channel when the
// pass granted something, otherwise idles until a restart event. Also keeps
// the sticky unsupported-flow flags. Assumes ready/bad inputs are combinational.
module dma_scan_ctl #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en_i,
    input  logic              kick_i,
    input  logic              req_changed_i,
    input  logic [NUM_CH-1:0] ready_i,
    input  logic [NUM_CH-1:0] bad_flow_i,
    input  logic [NUM_CH-1:0] chan_on_i,
    output logic              grant_vld_o,
    output logic [NUM_CH-1:0] grant_o,
    output logic [NUM_CH-1:0] flow_err_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    logic              scanning_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pass_hit_q;
    logic              restart;
    logic              cur_ready;
    logic              cur_bad;
    logic [NUM_CH-1:0] err_q;
    logic [NUM_CH-1:0] err_d;

    // Restart events and the view of the channel under the pointer (R1, R9).
    always_comb begin
        restart   = kick_i | req_changed_i;
        cur_ready = scanning_q & glb_en_i & ready_i[idx_q];
        cur_bad   = scanning_q & glb_en_i & bad_flow_i[idx_q];
    end

    // One-hot grant for the channel under the pointer (R8).
    always_comb begin
        grant_o          = '0;
        grant_o[idx_q]   = cur_ready;
        grant_vld_o      = cur_ready;
    end

    // Pointer, pass-hit flag and idle/scan state (R7, R9, R10, R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scanning_q <= 1'b0;
            idx_q      <= '0;
            pass_hit_q <= 1'b0;
        end else if (restart) begin
            scanning_q <= 1'b1;
            idx_q      <= '0;
            pass_hit_q <= 1'b0;
        end else if (scanning_q) begin
            if (cur_ready) begin
                pass_hit_q <= 1'b1;
            end else if (idx_q == LAST_IDX) begin
                idx_q      <= '0;
                pass_hit_q <= 1'b0;
                scanning_q <= pass_hit_q;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Next value of the sticky flags: set on visit, clear when channel off (R6).
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            err_d[c] = chan_on_i[c] & (err_q[c] | (cur_bad & (idx_q == IDX_W'(c))));
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign flow_err_o = err_q;

    // A grant without restart keeps the pointer on the same channel.
    assert_hold_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ready && !restart) |=> (scanning_q && idx_q == $past(idx_q)));

    // A restart event lands on channel 0 while scanning.
    assert_restart_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (scanning_q && idx_q == '0));

    // Idle persists without a restart event.
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning_q && !restart) |=> !scanning_q);

    // No grant without an active scan.
    assert_idle_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning_q |-> !grant_vld_o);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_err_chk
            // A flag only rises after its channel was visited with a bad flow type.
            assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(err_q[c]) |-> ($past(cur_bad) && $past(idx_q) == IDX_W'(c)));
        end
    endgenerate

endmodule

// File: rtl/dma_chan_sched.sv
// Module: top of the DMA channel request scheduler. Slices the flat channel
// buses, builds one eligibility unit per channel, and hands the results to
// the scan controller. Assumes the engine lowers the granted channel's count
// by one at the clock edge that ends each valid cycle.
module dma_chan_sched import dma_sched_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    glb_en,
    input  logic                    kick,
    input  logic [NUM_CH*CFG_W-1:0] chan_cfg,
    input  logic [NUM_CH*CNT_W-1:0] chan_cnt,
    input  logic [REQ_W-1:0]        req_single,
    input  logic [REQ_W-1:0]        req_burst,
    output logic                    grant_vld,
    output logic [NUM_CH-1:0]       grant,
    output logic [NUM_CH-1:0]       flow_err
);

    logic [REQ_W-1:0]  req_any;
    logic              req_changed;
    logic [NUM_CH-1:0] ready;
    logic [NUM_CH-1:0] bad_flow;
    logic [NUM_CH-1:0] chan_on;

    dma_req_watch u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_single_i  (req_single),
        .req_burst_i   (req_burst),
        .req_any_o     (req_any),
        .req_changed_o (req_changed)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            dma_chan_elig #(.CNT_W(CNT_W)) u_elig (
                .cfg_i      (chan_cfg[c*CFG_W +: CFG_W]),
                .cnt_i      (chan_cnt[c*CNT_W +: CNT_W]),
                .req_any_i  (req_any),
                .ready_o    (ready[c]),
                .bad_flow_o (bad_flow[c])
            );
            assign chan_on[c] = chan_cfg[c*CFG_W + CFG_EN_BIT];

            // Granted channel is enabled and not halted at the ports.
            assert_grant_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
                grant[c] |-> (chan_cfg[c*CFG_W + CFG_EN_BIT] && !chan_cfg[c*CFG_W + CFG_HALT_BIT]));

            // Granted channel has work left.
            assert_grant_has_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
                grant[c] |-> (chan_cnt[c*CNT_W +: CNT_W] != '0));

            // Unsupported flow types never receive a grant.
            assert_bad_flow_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
                chan_cfg[c*CFG_W + FLOW_LSB + 2] |-> !grant[c]);
        end
    endgenerate

    dma_scan_ctl #(.NUM_CH(NUM_CH)) u_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .glb_en_i      (glb_en),
        .kick_i        (kick),
        .req_changed_i (req_changed),
        .ready_i       (ready),
        .bad_flow_i    (bad_flow),
        .chan_on_i     (chan_on),
        .grant_vld_o   (grant_vld),
        .grant_o       (grant),
        .flow_err_o    (flow_err)
    );

    // Global enable gates every grant.
    assert_no_grant_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> glb_en);

    // Grant shape follows valid.
    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> $onehot(grant));
    assert_grant_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (grant == '0));

endmodule

// File: tb/dma_chan_sched_tb.sv
// Bench: sweeps flow types and request patterns on a 4-channel build, models
// the transfer engine's count decrement, and compares grant totals and order.
module dma_chan_sched_tb_top;

    localparam int NCH = 4;
    localparam int CW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              glb_en;
    logic              kick;
    logic [31:0]       rs;
    logic [31:0]       rb;
    logic [31:0]       cfg_arr [NCH];
    logic [CW-1:0]     cnt_arr [NCH];
    logic [CW-1:0]     load_val [NCH];
    logic [NCH-1:0]    load_mask;
    logic [NCH*32-1:0] cfg_flat;
    logic [NCH*CW-1:0] cnt_flat;
    logic              grant_vld;
    logic [NCH-1:0]    grant;
    logic [NCH-1:0]    flow_err;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg_flat[i*32 +: 32] = cfg_arr[i];
            cnt_flat[i*CW +: CW] = cnt_arr[i];
        end
    end

    dma_chan_sched #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_en     (glb_en),
        .kick       (kick),
        .chan_cfg   (cfg_flat),
        .chan_cnt   (cnt_flat),
        .req_single (rs),
        .req_burst  (rb),
        .grant_vld  (grant_vld),
        .grant      (grant),
        .flow_err   (flow_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Monitor state, written only by the negedge monitor.
    int   gcnt [NCH];
    int   log_ch [4096];
    int   log_n = 0;
    int   bad_hot = 0;
    logic dec_pend = 1'b0;
    int   dec_idx = 0;

    initial for (int i = 0; i < NCH; i++) gcnt[i] = 0;

    // Record grants away from the clock edge and check grant shape (R8).
    always @(negedge clk) begin
        if (grant_vld) begin
            int k;
            k = 0;
            if ($countones(grant) != 1) bad_hot++;
            for (int i = 0; i < NCH; i++) if (grant[i]) k = i;
            gcnt[k]++;
            if (log_n < 4096) log_ch[log_n] = k;
            log_n++;
            dec_pend = 1'b1;
            dec_idx  = k;
        end else begin
            if (grant != '0) bad_hot++;
            dec_pend = 1'b0;
        end
    end

    // Engine model: loads from the stimulus, decrement per granted element.
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (load_mask[i])                   cnt_arr[i] <= load_val[i];
            else if (dec_pend && dec_idx == i)  cnt_arr[i] <= cnt_arr[i] - 1'b1;
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #2000000;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input bit en, input bit halt, input int flow,
                                          input int src, input int dst);
        logic [31:0] w;
        w = '0;
        w[0]     = en;
        w[5:1]   = src[4:0];
        w[10:6]  = dst[4:0];
        w[13:11] = flow[2:0];
        w[18]    = halt;
        return w;
    endfunction

    // Expected grant total for a channel under static inputs (R2..R5).
    function automatic int exp_grants(input logic [31:0] w, input int cnt,
                                      input logic [31:0] req);
        bit s;
        bit d;
        bit ok;
        int fl;
        if (!w[0] || w[18] || cnt == 0) return 0;
        fl = int'(w[13:11]);
        s  = req[w[5:1]];
        d  = req[w[10:6]];
        ok = (fl == 0) || (fl == 1 && d) || (fl == 2 && s) || (fl == 3 && s && d);
        return ok ? cnt : 0;
    endfunction

    int base_g [NCH];
    int base_log;

    task automatic snap();
        for (int i = 0; i < NCH; i++) base_g[i] = gcnt[i];
        base_log = log_n;
    endtask

    function automatic int delta(input int c);
        return gcnt[c] - base_g[c];
    endfunction

    function automatic int order_breaks();
        int nb;
        nb = 0;
        for (int i = base_log + 1; i < log_n; i++) if (log_ch[i] < log_ch[i-1]) nb++;
        return nb;
    endfunction

    task automatic commit();
        @(negedge clk);
        load_mask = '0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NCH; i++) begin
            cfg_arr[i]  = '0;
            load_val[i] = '0;
        end
        load_mask = '1;
        rs = '0;
        rb = '0;
        commit();
        repeat (2*NCH + 4) @(negedge clk);
    endtask

    task automatic run_case(input int cycles);
        commit();
        pulse_kick();
        repeat (cycles) @(negedge clk);
    endtask

    logic [31:0] lf;
    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        int e;
        int first0;
        int last3;
        glb_en = 1'b1;
        kick = 1'b0;
        rs = '0;
        rb = '0;
        load_mask = '1;
        for (int i = 0; i < NCH; i++) begin
            cfg_arr[i] = '0;
            load_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(grant_vld == 1'b0, "R11 valid in reset", int'(grant_vld), 0);
        chk(flow_err == '0, "R11 flags in reset", int'(flow_err), 0);
        rst_n = 1'b1;
        load_mask = '0;
        repeat (2) @(negedge clk);
        chk(grant == '0, "R11 grant after reset", int'(grant), 0);

        // R3/R4/R6 sweep: every channel, flow type and request pattern.
        for (int c = 0; c < NCH; c++) begin
            for (int f = 0; f < 8; f++) begin
                for (int p = 0; p < 4; p++) begin
                    int ps;
                    int pd;
                    int exp;
                    bit s;
                    bit d;
                    ps = (c*7 + 3) % 32;
                    pd = (c*11 + 20) % 32;
                    s = p[0];
                    d = p[1];
                    clear_all();
                    snap();
                    cfg_arr[c] = mkcfg(1'b1, 1'b0, f, ps, pd);
                    // R3: alternate which vector carries each request bit.
                    if (f % 2 == 1) begin
                        rs = s ? (32'd1 << ps) : 32'd0;
                        rb = d ? (32'd1 << pd) : 32'd0;
                    end else begin
                        rb = s ? (32'd1 << ps) : 32'd0;
                        rs = d ? (32'd1 << pd) : 32'd0;
                    end
                    load_val[c] = 4'd3;
                    load_mask[c] = 1'b1;
                    run_case(20);
                    exp = exp_grants(cfg_arr[c], 3, rs | rb);
                    chk(delta(c) == exp, "R3 R4 flow grants", delta(c), exp);
                    chk(flow_err[c] == (f >= 4), "R6 flag", int'(flow_err[c]), int'(f >= 4));
                end
            end
        end

        // R6: flag clears when channel enable goes low.
        clear_all();
        cfg_arr[1] = mkcfg(1'b1, 1'b0, 6, 0, 1);
        load_val[1] = 4'd2;
        load_mask[1] = 1'b1;
        run_case(12);
        chk(flow_err[1] == 1'b1, "R6 flag set", int'(flow_err[1]), 1);
        cfg_arr[1] = '0;
        repeat (2) @(negedge clk);
        chk(flow_err[1] == 1'b0, "R6 flag cleared", int'(flow_err[1]), 0);

        // R7: all channels free-running, fixed counts.
        clear_all();
        snap();
        for (int i = 0; i < NCH; i++) begin
            cfg_arr[i] = mkcfg(1'b1, 1'b0, 0, 0, 0);
            load_val[i] = CW'((i*5 + 3) % 5 + 1);
            load_mask[i] = 1'b1;
        end
        run_case(40);
        for (int i = 0; i < NCH; i++)
            chk(delta(i) == (i*5 + 3) % 5 + 1, "R7 per-channel total", delta(i), (i*5 + 3) % 5 + 1);
        chk(order_breaks() == 0, "R7 ascending order", order_breaks(), 0);

        // R2/R5/R7: pseudo-random mixes of enable, halt, flow, requests, counts.
        lf = 32'h1234_5679;
        for (int k = 0; k < 24; k++) begin
            int expv [NCH];
            logic [31:0] req;
            clear_all();
            snap();
            for (int i = 0; i < NCH; i++) begin
                lf = nxt(lf);
                cfg_arr[i] = mkcfg(lf[0] | lf[1], lf[2] & lf[3], int'(lf[5:4]),
                                   int'(lf[10:6]), int'(lf[15:11]));
                load_val[i] = lf[19:16];
                load_mask[i] = 1'b1;
            end
            lf = nxt(lf);
            rs = lf;
            lf = nxt(lf);
            rb = lf & 32'h0F0F_0F0F;
            req = rs | rb;
            for (int i = 0; i < NCH; i++) expv[i] = exp_grants(cfg_arr[i], int'(load_val[i]), req);
            run_case(90);
            for (int i = 0; i < NCH; i++)
                chk(delta(i) == expv[i], "R2 R5 random mix total", delta(i), expv[i]);
            chk(order_breaks() == 0, "R7 random mix order", order_breaks(), 0);
        end

        // R5: zero count skipped, next channel still served.
        clear_all();
        snap();
        cfg_arr[0] = mkcfg(1'b1, 1'b0, 0, 0, 0);
        cfg_arr[1] = mkcfg(1'b1, 1'b0, 0, 0, 0);
        load_val[0] = 4'd0;
        load_val[1] = 4'd2;
        load_mask = '1;
        run_case(20);
        chk(delta(0) == 0, "R5 zero count", delta(0), 0);
        chk(delta(1) == 2, "R5 next served", delta(1), 2);

        // R1 and R10: disabled pass, then enable without kick, then kick.
        clear_all();
        snap();
        glb_en = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            cfg_arr[i] = mkcfg(1'b1, 1'b0, 0, 0, 0);
            load_val[i] = 4'd2;
            load_mask[i] = 1'b1;
        end
        run_case(20);
        e = delta(0) + delta(1) + delta(2) + delta(3);
        chk(e == 0, "R1 disabled grants", e, 0);
        glb_en = 1'b1;
        repeat (20) @(negedge clk);
        e = delta(0) + delta(1) + delta(2) + delta(3);
        chk(e == 0, "R10 idle without kick", e, 0);
        pulse_kick();
        repeat (20) @(negedge clk);
        e = delta(0) + delta(1) + delta(2) + delta(3);
        chk(e == 8, "R10 resumed after kick", e, 8);

        // R10: new count after an empty pass stays unserved until kick.
        snap();
        load_val[2] = 4'd3;
        load_mask = 4'b0100;
        commit();
        repeat (15) @(negedge clk);
        chk(delta(2) == 0, "R10 no grant on new work", delta(2), 0);

        // R9: request change in mid-pass pulls the scan back to channel 0.
        clear_all();
        snap();
        cfg_arr[0] = mkcfg(1'b1, 1'b0, 1, 9, 3);
        cfg_arr[2] = mkcfg(1'b1, 1'b0, 0, 0, 0);
        load_val[0] = 4'd2;
        load_val[2] = 4'd12;
        load_mask = '1;
        run_case(6);
        rb = 32'd1 << 3;
        repeat (30) @(negedge clk);
        first0 = -1;
        last3 = -1;
        for (int i = base_log; i < log_n; i++) begin
            if (log_ch[i] == 0 && first0 < 0) first0 = i;
            if (log_ch[i] == 2) last3 = i;
        end
        chk(delta(0) == 2 && delta(2) == 12, "R9 totals after req change", delta(0)*100 + delta(2), 212);
        chk(first0 > base_log && first0 < last3, "R9 req change preempts pass", first0 - base_log, 1);

        // R9: kick in mid-pass also restarts at channel 0.
        clear_all();
        snap();
        cfg_arr[0] = mkcfg(1'b1, 1'b0, 0, 0, 0);
        cfg_arr[3] = mkcfg(1'b1, 1'b0, 0, 0, 0);
        load_val[3] = 4'd12;
        load_mask = '1;
        run_case(6);
        load_val[0] = 4'd2;
        load_mask = 4'b0001;
        commit();
        pulse_kick();
        repeat (30) @(negedge clk);
        first0 = -1;
        last3 = -1;
        for (int i = base_log; i < log_n; i++) begin
            if (log_ch[i] == 0 && first0 < 0) first0 = i;
            if (log_ch[i] == 3) last3 = i;
        end
        chk(delta(0) == 2 && delta(3) == 12, "R9 totals after kick", delta(0)*100 + delta(3), 212);
        chk(first0 > base_log && first0 < last3, "R9 kick preempts pass", first0 - base_log, 1);

        // R8: grant shape over the whole run.
        chk(bad_hot == 0, "R8 one-hot grant", bad_hot, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule